// File: doc/BRIEF.md
# Two-Node Oven Thermal Plant Emulator

This block stands in for a real oven so that a temperature controller can be run in closed loop on silicon. It takes a heater power command in watts and an ambient temperature in degrees Celsius. It reports the oven's inner temperature in whole degrees. Inside it there are two thermal nodes, each held as a fixed-point temperature with 16 fractional bits. The heater element has a capacity of 500 J/°C and reaches the oven chamber through 0.143 °C/W. The chamber has a capacity of 1000 J/°C and loses heat to the surroundings through 0.1 °C/W of insulation.

The model takes one explicit one-second step on each clock-enable pulse. Every heat flow in a step is computed from the node values that the previous step left behind. This delay of one step breaks the loop that would otherwise join the two integrators. Divisions are done as multiplications by fixed-point reciprocal constants followed by arithmetic right shifts, which round toward minus infinity. Only the reported temperature is reduced to whole degrees.

Top module: `oven_plant`

## Requirements
- R1: While rst_n is low at a clock edge, both node states load the clamped ambient temperature (integer part, zero fraction), and temp_out loads that same clamped value.
- R2: The ambient input te is clamped to the range 10 to 30 before any use: a value below 10 acts as 10 and a value above 30 acts as 30.
- R3: Node states and temp_out change only at a clock edge where ce is high. At every other edge they hold.
- R4: On a step, with P = power·2^16 and Fh = ((Th − To)·1790) >>> 8, the heater state becomes Th + (((P − Fh)·33554) >>> 24). All values are in Q16.
- R5: On a step, with Fl = ((To − Te·2^16)·2560) >>> 8, the oven state becomes To + (((Fh − Fl)·16777) >>> 24).
- R6: Both updates in one step use the pre-step values of Th and To. So a first powered step from equilibrium leaves the oven output unchanged.
- R7: After the edge where a step is taken, temp_out shows the new oven state truncated toward zero to whole degrees, as a signed 12-bit value.
- R8: With zero power and both nodes at the clamped ambient, a step leaves both nodes unchanged.
- R9: A step with nonzero power and the heater not hotter than the oven strictly raises the heater state. Sustained power lifts temp_out above ambient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads ambient into both nodes |
| ce | input | 1 | Step strobe, one model second per high cycle |
| power | input | 13 | Heater power command in watts, unsigned |
| te | input | 8 | Ambient temperature in °C, unsigned, clamped to 10..30 |
| temp_out | output | 12 | Oven temperature in whole °C, signed, truncated toward zero |

## Verification
Every result is registered, so temp_out reflects a step at the first clock edge where ce is high, and it must then stay fixed until the next strobe. The bench drives inputs and the one-cycle strobe on the falling edge. It samples temp_out on the following falling edge, which is half a cycle after the updating edge, and compares it there with a Q16 model built from the step equations. Tests for holding and reset sample again after several idle edges. This shows that nothing moves without a strobe.

// File: rtl/oven_plant.sv
module oven_plant #(
  parameter int W_PWR   = 13,
  parameter int W_TE    = 8,
  parameter int W_TOUT  = 12,
  parameter int FRAC    = 16,
  parameter int W_STATE = 32,
  parameter int TE_MIN  = 10,
  parameter int TE_MAX  = 30,
  parameter int K_HO    = 1790,
  parameter int K_LOSS  = 2560,
  parameter int SH_R    = 8,
  parameter int K_CH    = 33554,
  parameter int K_CO    = 16777,
  parameter int SH_C    = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce,
  input  logic [W_PWR-1:0]         power,
  input  logic [W_TE-1:0]          te,
  output logic signed [W_TOUT-1:0] temp_out
);
  localparam int W_ACC = 2 * W_STATE;

  logic signed [W_STATE-1:0] th_q, to_q, th_nx, to_nx, te_fx, p_fx, to_mag;
  logic [W_STATE-1:0]        ip, tout_nx;
  logic [W_TE-1:0]           te_c;
  logic signed [W_ACC-1:0]   dh, dl, flow_h, flow_l, gain_h, gain_o;

  assign te_c = (te < W_TE'(TE_MIN)) ? W_TE'(TE_MIN) :
                (te > W_TE'(TE_MAX)) ? W_TE'(TE_MAX) : te;

  assign te_fx = $signed(W_STATE'(te_c)) <<< FRAC;
  assign p_fx  = $signed(W_STATE'(power)) <<< FRAC;

  assign dh     = W_ACC'(th_q) - W_ACC'(to_q);
  assign dl     = W_ACC'(to_q) - W_ACC'(te_fx);
  assign flow_h = (dh * W_ACC'(K_HO)) >>> SH_R;
  assign flow_l = (dl * W_ACC'(K_LOSS)) >>> SH_R;
  assign gain_h = ((W_ACC'(p_fx) - flow_h) * W_ACC'(K_CH)) >>> SH_C;
  assign gain_o = ((flow_h - flow_l) * W_ACC'(K_CO)) >>> SH_C;

  assign th_nx = th_q + W_STATE'(gain_h);
  assign to_nx = to_q + W_STATE'(gain_o);

  assign to_mag  = to_nx[W_STATE-1] ? -to_nx : to_nx;
  assign ip      = to_mag >> FRAC;
  assign tout_nx = to_nx[W_STATE-1] ? -ip : ip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      th_q     <= te_fx;
      to_q     <= te_fx;
      temp_out <= W_TOUT'(te_c);
    end else if (ce) begin
      th_q     <= th_nx;
      to_q     <= to_nx;
      temp_out <= W_TOUT'(tout_nx);
    end
  end
endmodule

// File: rtl/oven_plant_chk.sv
module oven_plant_chk #(
  parameter int W_PWR   = 13,
  parameter int W_TOUT  = 12,
  parameter int W_STATE = 32,
  parameter int TE_MIN  = 10,
  parameter int TE_MAX  = 30
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ce,
  input logic [W_PWR-1:0]          power,
  input logic signed [W_TOUT-1:0]  temp_out,
  input logic signed [W_STATE-1:0] th_q,
  input logic signed [W_STATE-1:0] to_q,
  input logic signed [W_STATE-1:0] te_fx
);
  p_reset_range_r1: assert property (@(posedge clk)
    !rst_n |=> (temp_out >= TE_MIN && temp_out <= TE_MAX));

  p_hold_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(temp_out));

  p_hold_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(th_q) && $stable(to_q)));

  p_equilibrium_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && power == '0 && th_q == to_q && to_q == te_fx) |=>
      ($stable(th_q) && $stable(to_q)));

  p_heater_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && power != '0 && th_q <= to_q) |=> (th_q > $past(th_q)));
endmodule

bind oven_plant oven_plant_chk #(
  .W_PWR(W_PWR), .W_TOUT(W_TOUT), .W_STATE(W_STATE),
  .TE_MIN(TE_MIN), .TE_MAX(TE_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .power(power), .temp_out(temp_out),
  .th_q(th_q), .to_q(to_q), .te_fx(te_fx)
);

// File: tb/oven_plant_tb.sv
`timescale 1ns/1ps
module oven_plant_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce = 1'b0;
  logic [12:0]       power = '0;
  logic [7:0]        te = 8'd25;
  logic signed [11:0] temp_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  longint mth, mto;

  always #2.5 clk = ~clk;

  oven_plant u_dut (.clk(clk), .rst_n(rst_n), .ce(ce), .power(power),
                    .te(te), .temp_out(temp_out));

  // {power[12:0], te[7:0], steps[10:0]}
  localparam logic [31:0] VEC [6] = '{
    {13'd5000, 8'd25, 11'd300},
    {13'd0,    8'd25, 11'd100},
    {13'd1150, 8'd25, 11'd200},
    {13'd8191, 8'd30, 11'd100},
    {13'd300,  8'd5,  11'd50},
    {13'd2000, 8'd60, 11'd50}
  };

  function automatic longint clamp_te(int t);
    if (t < 10) return 10;
    if (t > 30) return 30;
    return longint'(t);
  endfunction

  function automatic int trunc0(longint v);
    if (v < 0) return -int'((-v) >>> 16);
    return int'(v >>> 16);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: temp_out=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset(int t);
    mth = clamp_te(t) <<< 16;
    mto = mth;
  endtask

  task automatic model_step(int p, int t);
    longint tf, fh, fl, nth, nto;
    tf  = clamp_te(t) <<< 16;
    fh  = ((mth - mto) * 1790) >>> 8;
    fl  = ((mto - tf) * 2560) >>> 8;
    nth = mth + ((((longint'(p) <<< 16) - fh) * 33554) >>> 24);
    nto = mto + (((fh - fl) * 16777) >>> 24);
    mth = nth;
    mto = nto;
  endtask

  task automatic do_reset(int t);
    @(negedge clk);
    rst_n = 1'b0; ce = 1'b0; te = 8'(t);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset(t);
  endtask

  task automatic do_step(int p, int t);
    @(negedge clk);
    power = 13'(p); te = 8'(t); ce = 1'b1;
    @(negedge clk);
    ce = 1'b0;
    model_step(p, t);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hold_val;
    do_reset(25);
    check("R1 reset loads ambient", int'(temp_out), 25);

    // R6: first powered step from equilibrium leaves oven at ambient
    do_step(5000, 25);
    check("R6 previous-step values", int'(temp_out), 25);

    // Vector table walk, compared against R4/R5/R7 model every step
    do_reset(25);
    for (int v = 0; v < 6; v++) begin
      for (int s = 0; s < int'(VEC[v][10:0]); s++) begin
        do_step(int'(VEC[v][31:19]), int'(VEC[v][18:11]));
        check("R4 R5 R7 step model", int'(temp_out), trunc0(mto));
      end
    end

    // R3: no strobe, inputs change, output holds
    hold_val = int'(temp_out);
    @(negedge clk);
    power = 13'd8000; te = 8'd10;
    repeat (20) @(negedge clk);
    check("R3 hold without ce", int'(temp_out), hold_val);
    do_step(8000, 10);
    check("R3 state held then stepped", int'(temp_out), trunc0(mto));

    // R2: clamp at reset, low and high
    do_reset(3);
    check("R2 low clamp at reset", int'(temp_out), 10);
    do_reset(200);
    check("R2 high clamp at reset", int'(temp_out), 30);

    // R8: zero power at equilibrium stays put
    do_reset(18);
    for (int s = 0; s < 40; s++) do_step(0, 18);
    check("R8 equilibrium holds", int'(temp_out), 18);

    // R2: ambient above range during run behaves as 30
    do_reset(30);
    for (int s = 0; s < 60; s++) do_step(0, 90);
    check("R2 high clamp in run", int'(temp_out), 30);

    // R9: sustained heating lifts oven above ambient
    do_reset(20);
    for (int s = 0; s < 400; s++) do_step(5000, 20);
    check("R9 model after heating", int'(temp_out), trunc0(mto));
    checks++;
    if (!(int'(temp_out) > 20)) begin
      errors++;
      $display("FAIL R9: temp_out=%0d expected >20", temp_out);
    end

    // R1: reset mid-run returns to ambient
    do_reset(12);
    check("R1 reset mid-run", int'(temp_out), 12);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule